// File: doc/BRIEF.md
# Dispatch Group Former

The block accepts decoded micro-ops one at a time, in program order, and packs them into five-slot dispatch groups. Each incoming op carries four tag bits: branch, condition-register op, cracked (the op expands into two halves, carried on two payload fields), and millicoded. The block places each op in the next free slot of the group it is building. When an op cannot legally join that group, the block closes the group and starts a new one. Slots that a rule leaves unused leave the block as bubbles.

A closed group goes to a one-entry output register. The register presents a per-slot valid mask and the five payload fields under a valid/ready handshake. The input side uses its own valid/ready pair. A group that has four ordinary ops stays open until the next op arrives, because that op might be a branch that can complete it.

Top module: `dispatch_group_former`

## Requirements
- R1: After reset no group is being built, `grp_valid` is 0 and `in_ready` is 1, so the first op accepted starts a fresh group at slot 0.
- R2: Accepted ops fill slots in arrival order, starting at slot 0 with no gaps. In every emitted group the valid bits below slot 4 form a contiguous run from bit 0.
- R3: A branch always lands in slot 4 (mask bit 4) and closes its group. Slots between the last placed op and slot 4 are bubbles: mask bit 0 and an all-zero payload.
- R4: Slot 4 never holds a non-branch op. A non-branch op that arrives while slots 0 to 3 are full closes that group with slot 4 empty and takes slot 0 of the next group.
- R5: A condition-register op may sit only in slot 0 or 1. If it arrives when two or more slots are already used, the current group closes and the op takes slot 0 of a new group.
- R6: A cracked op places its first half (`in_op_a`) and then its second half (`in_op_b`) in adjacent slots of the same group. If fewer than two of slots 0 to 3 remain, the current group closes and the pair takes slots 0 and 1 of a new group.
- R7: The op after a cracked pair joins the same group when a legal slot remains.
- R8: A millicoded op closes any partial group, takes slot 0 of a group of its own, and that group is emitted with mask 5'b00001. The next op starts a new group.
- R9: When several tags are set, the tags are taken in this order: millicoded, then branch, then cracked, then condition-register. `in_op_b` is ignored unless the op is treated as cracked.
- R10: While `grp_valid` is 1 and `grp_ready` is 0, the group outputs hold steady. No op is lost or duplicated under back-pressure on either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An op is offered |
| in_ready | output | 1 | The block takes the offered op on this edge |
| in_op_a | input | OP_W | Payload of the op (first half when cracked) |
| in_op_b | input | OP_W | Second half of a cracked op |
| in_branch | input | 1 | Op is a branch |
| in_cr | input | 1 | Op targets the condition-register unit |
| in_cracked | input | 1 | Op occupies two slots |
| in_milli | input | 1 | Op is millicoded |
| grp_valid | output | 1 | A closed group is presented |
| grp_ready | input | 1 | Consumer takes the group on this edge |
| grp_mask | output | NUM_SLOTS | Per-slot valid; a 0 marks a bubble |
| grp_ops | output | NUM_SLOTS*OP_W | Slot payloads, slot 0 in the low bits |

## Verification
The bench uses the default build: five slots, two condition-register slots and 16-bit payloads. These values keep every placement boundary within reach of a few ops. The boundaries are the fifth ordinary op, a condition-register op at slot 2, and a cracked pair that starts at slot 3. Payloads are kept nonzero, so a bubble can be told apart from a real op by its payload as well as by its mask bit. A long mixed run with random back-pressure on the group output exercises R10 together with the placement rules at the same time.

// File: rtl/dgf_pkg.sv
package dgf_pkg;

  typedef enum logic [2:0] {
    K_PLAIN  = 3'd0,
    K_CR     = 3'd1,
    K_CRACK  = 3'd2,
    K_BRANCH = 3'd3,
    K_MILLI  = 3'd4
  } op_kind_e;

  // Tag precedence: millicode, branch, cracked, condition-register.
  function automatic op_kind_e decode_kind(input logic milli, input logic branch,
                                           input logic cracked, input logic cr);
    if (milli)        return K_MILLI;
    else if (branch)  return K_BRANCH;
    else if (cracked) return K_CRACK;
    else if (cr)      return K_CR;
    else              return K_PLAIN;
  endfunction

  // Number of group slots an op of this kind consumes.
  function automatic logic [1:0] kind_len(input op_kind_e k);
    return (k == K_CRACK) ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/dgf_classify.sv
module dgf_classify
  import dgf_pkg::*;
(
  input  logic     milli,
  input  logic     branch,
  input  logic     cracked,
  input  logic     cr,
  output op_kind_e kind
);

  always_comb kind = decode_kind(milli, branch, cracked, cr);

endmodule

// File: rtl/dgf_slot_planner.sv
module dgf_slot_planner
  import dgf_pkg::*;
#(
  parameter int NUM_SLOTS = 5,
  parameter int OP_W      = 16,
  parameter int CR_SLOTS  = 2,
  parameter int PTR_W     = 3
) (
  input  logic [NUM_SLOTS-1:0]      acc_mask,
  input  logic [NUM_SLOTS*OP_W-1:0] acc_ops,
  input  logic [PTR_W-1:0]          acc_ptr,
  input  logic                      acc_sealed,
  input  logic                      take,
  input  logic                      out_free,
  input  op_kind_e                  kind,
  input  logic [OP_W-1:0]           op_a,
  input  logic [OP_W-1:0]           op_b,
  output logic [NUM_SLOTS-1:0]      nx_mask,
  output logic [NUM_SLOTS*OP_W-1:0] nx_ops,
  output logic [PTR_W-1:0]          nx_ptr,
  output logic                      nx_sealed,
  output logic                      push_v,
  output logic [NUM_SLOTS-1:0]      push_mask,
  output logic [NUM_SLOTS*OP_W-1:0] push_ops
);

  localparam int BR_SLOT = NUM_SLOTS - 1;
  localparam logic [PTR_W-1:0] BR_PTR    = PTR_W'(BR_SLOT);
  localparam logic [PTR_W-1:0] CR_PTR    = PTR_W'(CR_SLOTS);
  localparam logic [PTR_W-1:0] CRACK_MAX = PTR_W'(BR_SLOT - 2);

  logic                      fits;
  logic [NUM_SLOTS-1:0]      base_mask;
  logic [NUM_SLOTS*OP_W-1:0] base_ops;
  logic [PTR_W-1:0]          base_ptr;
  logic [PTR_W-1:0]          second_ptr;

  // Whether the offered op can still join the open group.
  always_comb begin
    unique case (kind)
      K_PLAIN: fits = (acc_ptr < BR_PTR);
      K_CR:    fits = (acc_ptr < CR_PTR);
      K_CRACK: fits = (acc_ptr <= CRACK_MAX);
      K_MILLI: fits = (acc_ptr == '0);
      default: fits = 1'b1;
    endcase
  end

  always_comb begin
    nx_mask    = acc_mask;
    nx_ops     = acc_ops;
    nx_ptr     = acc_ptr;
    nx_sealed  = acc_sealed;
    push_v     = 1'b0;
    push_mask  = acc_mask;
    push_ops   = acc_ops;
    base_mask  = acc_mask;
    base_ops   = acc_ops;
    base_ptr   = acc_ptr;
    second_ptr = acc_ptr + PTR_W'(1);
    if (acc_sealed) begin
      if (out_free) begin
        push_v    = 1'b1;
        nx_mask   = '0;
        nx_ops    = '0;
        nx_ptr    = '0;
        nx_sealed = 1'b0;
      end
    end else if (take) begin
      if (kind == K_BRANCH) begin
        push_v             = 1'b1;
        push_mask[BR_SLOT] = 1'b1;
        push_ops[BR_SLOT*OP_W +: OP_W] = op_a;
        nx_mask = '0;
        nx_ops  = '0;
        nx_ptr  = '0;
      end else begin
        if (!fits) begin
          push_v    = 1'b1;
          base_mask = '0;
          base_ops  = '0;
          base_ptr  = '0;
        end
        second_ptr = base_ptr + PTR_W'(1);
        nx_mask = base_mask;
        nx_ops  = base_ops;
        for (int s = 0; s < BR_SLOT; s++) begin
          if (PTR_W'(s) == base_ptr) begin
            nx_mask[s] = 1'b1;
            nx_ops[s*OP_W +: OP_W] = op_a;
          end
          if (kind == K_CRACK && PTR_W'(s) == second_ptr) begin
            nx_mask[s] = 1'b1;
            nx_ops[s*OP_W +: OP_W] = op_b;
          end
        end
        nx_ptr    = base_ptr + PTR_W'(kind_len(kind));
        nx_sealed = (kind == K_MILLI);
      end
    end
  end

endmodule

// File: rtl/dgf_out_stage.sv
module dgf_out_stage #(
  parameter int NUM_SLOTS = 5,
  parameter int OP_W      = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push_v,
  input  logic [NUM_SLOTS-1:0]      push_mask,
  input  logic [NUM_SLOTS*OP_W-1:0] push_ops,
  output logic                      out_free,
  output logic                      out_v,
  input  logic                      out_ready,
  output logic [NUM_SLOTS-1:0]      out_mask,
  output logic [NUM_SLOTS*OP_W-1:0] out_ops
);

  assign out_free = !out_v || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_v    <= 1'b0;
      out_mask <= '0;
      out_ops  <= '0;
    end else if (push_v) begin
      out_v    <= 1'b1;
      out_mask <= push_mask;
      out_ops  <= push_ops;
    end else if (out_ready) begin
      out_v <= 1'b0;
    end
  end

  AST_GRP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_v && !out_ready) |=> (out_v && $stable(out_mask) && $stable(out_ops))); // R10

  AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    push_v |-> out_free); // R10

endmodule

// File: rtl/dispatch_group_former.sv
module dispatch_group_former
  import dgf_pkg::*;
#(
  parameter int NUM_SLOTS = 5,
  parameter int OP_W      = 16,
  parameter int CR_SLOTS  = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [OP_W-1:0]           in_op_a,
  input  logic [OP_W-1:0]           in_op_b,
  input  logic                      in_branch,
  input  logic                      in_cr,
  input  logic                      in_cracked,
  input  logic                      in_milli,
  output logic                      grp_valid,
  input  logic                      grp_ready,
  output logic [NUM_SLOTS-1:0]      grp_mask,
  output logic [NUM_SLOTS*OP_W-1:0] grp_ops
);

  localparam int BR_SLOT = NUM_SLOTS - 1;
  localparam int PTR_W   = $clog2(NUM_SLOTS + 1);
  localparam logic [PTR_W-1:0] BR_PTR    = PTR_W'(BR_SLOT);
  localparam logic [PTR_W-1:0] CR_PTR    = PTR_W'(CR_SLOTS);
  localparam logic [PTR_W-1:0] CRACK_MAX = PTR_W'(BR_SLOT - 2);

  op_kind_e                  kind;
  logic                      take;
  logic                      out_free;
  logic [NUM_SLOTS-1:0]      acc_mask, nx_mask, push_mask;
  logic [NUM_SLOTS*OP_W-1:0] acc_ops, nx_ops, push_ops;
  logic [PTR_W-1:0]          acc_ptr, nx_ptr;
  logic                      acc_sealed, nx_sealed;
  logic                      push_v;
  logic                      low_prefix_ok;

  dgf_classify u_classify (
    .milli   (in_milli),
    .branch  (in_branch),
    .cracked (in_cracked),
    .cr      (in_cr),
    .kind    (kind)
  );

  assign in_ready = !acc_sealed && out_free;
  assign take     = in_valid && in_ready;

  dgf_slot_planner #(
    .NUM_SLOTS (NUM_SLOTS),
    .OP_W      (OP_W),
    .CR_SLOTS  (CR_SLOTS),
    .PTR_W     (PTR_W)
  ) u_planner (
    .acc_mask   (acc_mask),
    .acc_ops    (acc_ops),
    .acc_ptr    (acc_ptr),
    .acc_sealed (acc_sealed),
    .take       (take),
    .out_free   (out_free),
    .kind       (kind),
    .op_a       (in_op_a),
    .op_b       (in_op_b),
    .nx_mask    (nx_mask),
    .nx_ops     (nx_ops),
    .nx_ptr     (nx_ptr),
    .nx_sealed  (nx_sealed),
    .push_v     (push_v),
    .push_mask  (push_mask),
    .push_ops   (push_ops)
  );

  // Open group being assembled.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_mask   <= '0;
      acc_ops    <= '0;
      acc_ptr    <= '0;
      acc_sealed <= 1'b0;
    end else begin
      acc_mask   <= nx_mask;
      acc_ops    <= nx_ops;
      acc_ptr    <= nx_ptr;
      acc_sealed <= nx_sealed;
    end
  end

  dgf_out_stage #(
    .NUM_SLOTS (NUM_SLOTS),
    .OP_W      (OP_W)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_v    (push_v),
    .push_mask (push_mask),
    .push_ops  (push_ops),
    .out_free  (out_free),
    .out_v     (grp_valid),
    .out_ready (grp_ready),
    .out_mask  (grp_mask),
    .out_ops   (grp_ops)
  );

  // Observation: no hole below the branch slot in the emitted mask.
  always_comb begin
    logic gap;
    gap           = 1'b0;
    low_prefix_ok = 1'b1;
    for (int s = 0; s < BR_SLOT; s++) begin
      if (!grp_mask[s]) gap = 1'b1;
      else if (gap)     low_prefix_ok = 1'b0;
    end
  end

  AST_MASK_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    grp_valid |-> low_prefix_ok); // R2

  AST_BRANCH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (take && kind == K_BRANCH) |=> (grp_valid && grp_mask[BR_SLOT] && acc_ptr == '0)); // R3

  AST_PTR_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ptr <= BR_PTR); // R4

  AST_CR_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (take && kind == K_CR && acc_ptr >= CR_PTR) |=> (grp_valid && acc_ptr == PTR_W'(1))); // R5

  AST_CRACK_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (take && kind == K_CRACK && acc_ptr > CRACK_MAX) |=> (grp_valid && acc_ptr == PTR_W'(2))); // R6

  AST_MILLI_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
    acc_sealed |-> (acc_ptr == PTR_W'(1) && !in_ready)); // R8

  AST_MILLI_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_sealed && out_free) |=> (grp_valid && grp_mask == NUM_SLOTS'(1) && acc_ptr == '0)); // R8

endmodule

// File: tb/test_dispatch_group_former.sv
`timescale 1ns/1ps
module test_dispatch_group_former;

  localparam int NS = 5;
  localparam int W  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_op_a = '0, in_op_b = '0;
  logic          in_branch = 1'b0, in_cr = 1'b0, in_cracked = 1'b0, in_milli = 1'b0;
  logic          grp_valid;
  logic          grp_ready = 1'b1;
  logic [NS-1:0] grp_mask;
  logic [NS*W-1:0] grp_ops;

  always #2 clk = ~clk;

  dispatch_group_former #(.NUM_SLOTS(NS), .OP_W(W), .CR_SLOTS(2)) i_dispatch_group_former (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_op_a(in_op_a), .in_op_b(in_op_b),
    .in_branch(in_branch), .in_cr(in_cr), .in_cracked(in_cracked), .in_milli(in_milli),
    .grp_valid(grp_valid), .grp_ready(grp_ready), .grp_mask(grp_mask), .grp_ops(grp_ops)
  );

  typedef struct {
    logic [NS-1:0]   mask;
    logic [NS*W-1:0] ops;
    string           tag;
  } exp_t;

  exp_t   exp_q[$];
  int     n_chk = 0, n_bad = 0;
  string  cur_tag = "R1";
  bit     bp_on = 1'b0;
  logic [W-1:0] m_slot [NS];
  int     m_cnt = 0;
  logic [15:0] id = 16'h8001;

  task automatic chk(bit ok, string tag, string what, logic [NS*W-1:0] act, logic [NS*W-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // Reference: close the model's group and queue it as the next expected output.
  task automatic m_close();
    exp_t e;
    e.tag = cur_tag;
    for (int s = 0; s < NS; s++) begin
      e.mask[s] = (m_slot[s] != '0);
      e.ops[s*W +: W] = m_slot[s];
      m_slot[s] = '0;
    end
    m_cnt = 0;
    exp_q.push_back(e);
  endtask

  task automatic m_op(bit m, bit b, bit c, bit r, logic [W-1:0] a, logic [W-1:0] bb);
    if (m) begin
      if (m_cnt != 0) m_close();
      m_slot[0] = a; m_cnt = 1; m_close();
    end else if (b) begin
      m_slot[NS-1] = a; m_close();
    end else if (c) begin
      if (m_cnt + 2 > NS - 1) m_close();
      m_slot[m_cnt] = a; m_slot[m_cnt+1] = bb; m_cnt += 2;
    end else if (r) begin
      if (m_cnt >= 2) m_close();
      m_slot[m_cnt] = a; m_cnt++;
    end else begin
      if (m_cnt == NS - 1) m_close();
      m_slot[m_cnt] = a; m_cnt++;
    end
  endtask

  task automatic send(bit m, bit b, bit c, bit r, logic [W-1:0] bb = 16'h0);
    logic [W-1:0] a, b2;
    a  = id; id = id + 16'd1;
    b2 = (bb != '0) ? bb : (a ^ 16'h4000);
    m_op(m, b, c, r, a, b2);
    @(negedge clk); #1;
    in_valid = 1'b1; in_op_a = a; in_op_b = b2;
    in_milli = m; in_branch = b; in_cracked = c; in_cr = r;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic plain(); send(0, 0, 0, 0); endtask
  task automatic br();    send(0, 1, 0, 0); endtask
  task automatic crop();  send(0, 0, 0, 1); endtask
  task automatic crk();   send(0, 0, 1, 0); endtask
  task automatic mil();   send(1, 0, 0, 0); endtask

  // Scoreboard monitor.
  logic            hold_prev = 1'b0;
  logic [NS-1:0]   hold_mask;
  logic [NS*W-1:0] hold_ops;
  initial begin
    forever begin
      @(negedge clk);
      if (hold_prev)
        chk(grp_valid && grp_mask == hold_mask && grp_ops == hold_ops, "R10",
            "held group changed", {grp_mask, grp_ops}, {hold_mask, hold_ops});
      grp_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
      if (rst_n && grp_valid && grp_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected group", {grp_mask, grp_ops}, '0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(grp_mask == e.mask && grp_ops == e.ops, e.tag, "group", {grp_mask, grp_ops}, {e.mask, e.ops});
        end
      end
      hold_prev = grp_valid && !grp_ready;
      hold_mask = grp_mask;
      hold_ops  = grp_ops;
    end
  end

  bit done = 1'b0;
  initial begin
    #(4 * 150000);
    if (!done) begin
      chk(1'b0, "R10", "watchdog expired", '0, '0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) m_slot[s] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1: idle after reset
    chk(grp_valid == 1'b0, "R1", "grp_valid after reset", {79'b0, grp_valid}, '0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", {79'b0, in_ready}, 80'd1);
    cur_tag = "R1"; br();
    cur_tag = "R3"; plain(); plain(); br();
    cur_tag = "R2"; plain(); plain(); plain(); plain(); br();
    cur_tag = "R4"; plain(); plain(); plain(); plain(); plain(); br();
    cur_tag = "R5"; crop(); crop(); br();
    plain(); crop(); br();
    plain(); plain(); crop(); plain(); br();
    cur_tag = "R6"; plain(); plain(); crk(); br();
    plain(); plain(); plain(); crk(); br();
    crk(); crk(); br();
    cur_tag = "R7"; crk(); plain(); crop(); br();
    cur_tag = "R8"; plain(); plain(); mil(); plain(); br();
    mil(); mil(); plain(); br();
    cur_tag = "R9"; plain(); send(1, 1, 0, 0);
    plain(); plain(); plain(); send(0, 0, 1, 1); br();
    send(0, 1, 1, 0, 16'h7777); plain(); send(0, 0, 0, 1, 16'h5555); br();
    cur_tag = "R10"; bp_on = 1'b1;
    for (int i = 0; i < 300; i++) begin
      int k;
      k = $urandom % 12;
      if (k < 5) plain();
      else if (k < 7) crop();
      else if (k < 9) crk();
      else if (k < 11) br();
      else mil();
    end
    br();
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    bp_on = 1'b0;
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2", "groups left undelivered", 80'(exp_q.size()), '0);
    #1;
    chk(grp_valid == 1'b0, "R2", "extra group", {79'b0, grp_valid}, '0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule